// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bus Host

This block is the host end of a one-wire, open-drain serial link to a battery monitor. Each bit is carried by the width of a low pulse. To start a transaction the host holds the wire low as a break and then releases it for a recovery gap. It then sends a command byte: seven address bits and a direction flag. For a write, a data byte follows. For a read, the host releases the wire and decodes the byte the device sends back by measuring how long the device holds the wire low. A separate request holds the wire low for about two seconds, which resets the device's interface.

The wire has one output, `line_pull`. When it is high, an external open-drain driver pulls the wire low. When it is low, the wire is released. The block never drives the wire high. The sensed wire level passes through a two-flop synchroniser before any edge detection. `CYC_PER_US` gives the number of clock cycles per microsecond, and every timing is derived from it. A caller starts a transaction with `req_valid` while `busy` is low. It waits for the one-cycle `done` pulse, then reads `rdata` and the two error flags.

Top module: `pwbus_host`

## Requirements
- R1: After reset, `line_pull`, `busy`, `done`, `err_timeout` and `err_frame` are 0, and `rdata` is 0.
- R2: An accepted transaction begins with `line_pull` high for exactly 200 µs (break). It is then low for exactly 50 µs before the first bit.
- R3: A transmitted 1 is `line_pull` high for 30 µs, and a transmitted 0 is high for 115 µs. Each bit period is exactly 200 µs from one rising edge of `line_pull` to the next.
- R4: Transmitted bits go least significant first. Command bits 0..6 carry `req_addr`, and command bit 7 is the direction flag (1 = write, 0 = read). A write then sends `req_wdata`, and `done` follows at the end of the final 200 µs bit period.
- R5: In a read, a device low pulse of 20 to 50 µs decodes as 1 and one of 80 to 145 µs decodes as 0. Bits are assembled least significant first into `rdata`.
- R6: A received low pulse shorter than 20 µs, between 50 and 80 µs (exclusive), or longer than 145 µs ends the transaction with `err_frame` = 1. When the pulse runs too long, the error is raised while the wire is still low.
- R7: The device's first falling edge must arrive within 190 µs after the host releases the wire at the end of its last command bit. Each later falling edge must arrive within 250 µs after the previous rising edge. Otherwise the transaction ends with `err_timeout` = 1.
- R8: After the last received bit, a frame error or a timeout, the host keeps the wire released for 210 µs before it raises `done`.
- R9: An interface-reset request while idle drives `line_pull` high for `RST_LOW_US` µs. `done` is raised in the cycle the wire is released, with both error flags 0.
- R10: `busy` is high from the cycle after a request is accepted until the `done` cycle. `done` lasts one cycle, and requests that arrive while `busy` is high are ignored.
- R11: When `ifrst_req` and `req_valid` are both high in the same idle cycle, the interface reset is performed.
- R12: `rdata`, `err_timeout` and `err_frame` change only in a cycle where `done` is high. A write or an interface reset leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a transaction (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Byte to write |
| ifrst_req | input | 1 | Request a long-low interface reset |
| busy | output | 1 | Transaction or reset in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Device did not respond in time |
| err_frame | output | 1 | Received pulse width illegal |
| rdata | output | DATA_W | Last byte read |
| line_pull | output | 1 | 1 = pull the wire low, 0 = release |
| line_in | input | 1 | Sensed wire level |

## Verification
Host output is checked by measuring every pulse and gap on `line_pull` and decoding the bits from their widths. A write with a mixed data pattern separates the 1 and 0 pulse widths, the address and data order, and the direction flag. One read drives device pulses at the exact edges of both legal windows (20, 50, 80, 145 µs), which pins the decoder's thresholds. A second read uses random in-window widths and gaps, which shows decoding does not depend on the exact cycle length. Illegal widths of 19, 65 and 146 µs separate the three frame-error ranges. A silent device measures the response window, and simultaneous requests show which request takes precedence.

// File: rtl/pwbus_pkg.sv
package pwbus_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_IRST,
    S_BRK,
    S_REC,
    S_TX,
    S_RXW,
    S_RXL,
    S_TURN
  } pw_state_e;

  // Microseconds to clock cycles for a given clock rate.
  function automatic int unsigned us_to_cyc(input int unsigned us, input int unsigned cpu);
    return us * cpu;
  endfunction

endpackage

// File: rtl/pwbus_lsync.sv
module pwbus_lsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic fall,
  output logic rise
);
  // STAGES synchroniser flops plus one history flop for edges; idle wire is high.
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-1:0], line_in};
  end

  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];
  assign rise = ~sh_q[STAGES] & sh_q[STAGES-1];
endmodule

// File: rtl/pwbus_pwclass.sv
module pwbus_pwclass import pwbus_pkg::*; #(
  parameter int unsigned CW         = 16,
  parameter int unsigned CYC_PER_US = 1
) (
  input  logic [CW-1:0] width,
  output logic          is_one,
  output logic          is_zero,
  output logic          too_long
);
  localparam int unsigned ONE_MIN  = us_to_cyc(20,  CYC_PER_US);
  localparam int unsigned ONE_MAX  = us_to_cyc(50,  CYC_PER_US);
  localparam int unsigned ZERO_MIN = us_to_cyc(80,  CYC_PER_US);
  localparam int unsigned ZERO_MAX = us_to_cyc(145, CYC_PER_US);

  assign is_one   = (width >= CW'(ONE_MIN))  && (width <= CW'(ONE_MAX));
  assign is_zero  = (width >= CW'(ZERO_MIN)) && (width <= CW'(ZERO_MAX));
  assign too_long = (width >  CW'(ZERO_MAX));
endmodule

// File: rtl/pwbus_host.sv
module pwbus_host import pwbus_pkg::*; #(
  parameter int unsigned CYC_PER_US = 250,
  parameter int unsigned RST_LOW_US = 2000000,
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ifrst_req,
  output logic              busy,
  output logic              done,
  output logic              err_timeout,
  output logic              err_frame,
  output logic [DATA_W-1:0] rdata,
  output logic              line_pull,
  input  logic              line_in
);
  localparam int unsigned CMD_W  = ADDR_W + 1;
  localparam int unsigned TOT_W  = CMD_W + DATA_W;
  localparam int unsigned BW     = $clog2(TOT_W);
  localparam int unsigned N_BRK  = us_to_cyc(200, CYC_PER_US);
  localparam int unsigned N_REC  = us_to_cyc(50,  CYC_PER_US);
  localparam int unsigned N_ONE  = us_to_cyc(30,  CYC_PER_US);
  localparam int unsigned N_ZERO = us_to_cyc(115, CYC_PER_US);
  localparam int unsigned N_CYC  = us_to_cyc(200, CYC_PER_US);
  localparam int unsigned N_RSP  = us_to_cyc(190, CYC_PER_US);
  localparam int unsigned N_GAP  = us_to_cyc(250, CYC_PER_US);
  localparam int unsigned N_TRN  = us_to_cyc(210, CYC_PER_US);
  localparam int unsigned N_RST  = us_to_cyc(RST_LOW_US, CYC_PER_US);
  localparam int unsigned N_MAX  = (N_RST > N_GAP) ? N_RST : N_GAP;
  localparam int unsigned CW     = $clog2(N_MAX + 1);

  pw_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q;
  logic              cnt_clr, cnt_en;
  logic [BW-1:0]     idx_q, idx_d;
  logic              first_q, first_d;
  logic [TOT_W-1:0]  txw_q, txw_d;
  logic [DATA_W-1:0] rxs_q, rxs_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              etmo_q, etmo_d, efrm_q, efrm_d;
  logic              errt_q, errf_q;
  logic              done_q, done_d;
  logic              pull_c;
  logic              ln_fall, ln_rise;
  logic              is_one, is_zero, too_long;
  logic [CW-1:0]     width_w, low_len, wait_lim;

  pwbus_lsync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .fall(ln_fall), .rise(ln_rise)
  );

  // Pulse width: cycles spent in S_RXL plus the detect cycle.
  assign width_w = cnt_q + CW'(1);

  pwbus_pwclass #(.CW(CW), .CYC_PER_US(CYC_PER_US)) u_cls (
    .width(width_w), .is_one(is_one), .is_zero(is_zero), .too_long(too_long)
  );

  assign low_len  = txw_q[idx_q] ? CW'(N_ONE) : CW'(N_ZERO);
  assign wait_lim = first_q ? CW'(N_RSP - 1) : CW'(N_GAP - 1);
  assign cnt_en   = (state_q != S_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    idx_d   = idx_q;
    first_d = first_q;
    txw_d   = txw_q;
    rxs_d   = rxs_q;
    rdata_d = rdata_q;
    etmo_d  = etmo_q;
    efrm_d  = efrm_q;
    done_d  = 1'b0;
    pull_c  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        cnt_clr = 1'b1;
        if (ifrst_req) begin
          state_d = S_IRST;
          etmo_d  = 1'b0;
          efrm_d  = 1'b0;
        end else if (req_valid) begin
          state_d = S_BRK;
          txw_d   = {req_wdata, req_write, req_addr};
          etmo_d  = 1'b0;
          efrm_d  = 1'b0;
        end
      end
      S_IRST: begin
        pull_c = 1'b1;
        if (cnt_q == CW'(N_RST - 1)) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
      S_BRK: begin
        pull_c = 1'b1;
        if (cnt_q == CW'(N_BRK - 1)) begin
          state_d = S_REC;
          cnt_clr = 1'b1;
        end
      end
      S_REC: begin
        if (cnt_q == CW'(N_REC - 1)) begin
          state_d = S_TX;
          cnt_clr = 1'b1;
          idx_d   = '0;
        end
      end
      S_TX: begin
        pull_c = (cnt_q < low_len);
        if (!txw_q[CMD_W-1] && idx_q == BW'(CMD_W - 1) && cnt_q == low_len - CW'(1)) begin
          state_d = S_RXW;
          cnt_clr = 1'b1;
          idx_d   = '0;
          first_d = 1'b1;
        end else if (cnt_q == CW'(N_CYC - 1)) begin
          cnt_clr = 1'b1;
          if (idx_q == BW'(TOT_W - 1)) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
          end else begin
            idx_d = idx_q + BW'(1);
          end
        end
      end
      S_RXW: begin
        if (ln_fall) begin
          state_d = S_RXL;
          cnt_clr = 1'b1;
        end else if (cnt_q == wait_lim) begin
          state_d = S_TURN;
          cnt_clr = 1'b1;
          etmo_d  = 1'b1;
        end
      end
      S_RXL: begin
        if (ln_rise) begin
          cnt_clr = 1'b1;
          if (is_one || is_zero) begin
            rxs_d = {is_one, rxs_q[DATA_W-1:1]};
            if (idx_q == BW'(DATA_W - 1)) begin
              state_d = S_TURN;
            end else begin
              state_d = S_RXW;
              idx_d   = idx_q + BW'(1);
              first_d = 1'b0;
            end
          end else begin
            state_d = S_TURN;
            efrm_d  = 1'b1;
          end
        end else if (too_long) begin
          state_d = S_TURN;
          cnt_clr = 1'b1;
          efrm_d  = 1'b1;
        end
      end
      S_TURN: begin
        if (cnt_q == CW'(N_TRN - 1)) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
          rdata_d = rxs_q;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      first_q <= 1'b0;
      txw_q   <= '0;
      rxs_q   <= '0;
      rdata_q <= '0;
      etmo_q  <= 1'b0;
      efrm_q  <= 1'b0;
      errt_q  <= 1'b0;
      errf_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_clr)     cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_q + CW'(1);
      idx_q   <= idx_d;
      first_q <= first_d;
      txw_q   <= txw_d;
      rxs_q   <= rxs_d;
      rdata_q <= rdata_d;
      etmo_q  <= etmo_d;
      efrm_q  <= efrm_d;
      done_q  <= done_d;
      if (done_d) begin
        errt_q <= etmo_d;
        errf_q <= efrm_d;
      end
    end
  end

  assign busy        = (state_q != S_IDLE);
  assign done        = done_q;
  assign err_timeout = errt_q;
  assign err_frame   = errf_q;
  assign rdata       = rdata_q;
  assign line_pull   = pull_c;
endmodule

// File: rtl/pwbus_host_chk.sv
module pwbus_host_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              ifrst_req,
  input logic              busy,
  input logic              done,
  input logic              err_timeout,
  input logic              err_frame,
  input logic [DATA_W-1:0] rdata,
  input logic              line_pull
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_pull);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (req_valid || ifrst_req)) |=> busy);

  // R6 and R7 outcomes are exclusive.
  a_r6_one_error: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(err_timeout && err_frame));

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata));

  a_r12_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(err_timeout) && $stable(err_frame)));
endmodule

bind pwbus_host pwbus_host_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/pwbus_host_tb_top.sv
module pwbus_host_tb_top;
  logic       clk;
  logic       rst_n;
  logic       req_valid, req_write, ifrst_req;
  logic [6:0] req_addr;
  logic [7:0] req_wdata;
  logic       busy, done, err_timeout, err_frame;
  logic [7:0] rdata;
  logic       line_pull, line_in, dev_pull;
  int         checks = 0;
  int         fails  = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign line_in = ~(line_pull | dev_pull);

  pwbus_host #(.CYC_PER_US(1), .RST_LOW_US(3000)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ifrst_req(ifrst_req),
    .busy(busy), .done(done), .err_timeout(err_timeout), .err_frame(err_frame),
    .rdata(rdata), .line_pull(line_pull), .line_in(line_in)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Called at a negedge; returns at the first negedge where line_pull == lvl.
  task automatic wait_pull(input logic lvl, output int n);
    n = 0;
    while (line_pull !== lvl && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (done !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic start_req(input logic w, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Measures break, recovery and nbits host bits; decodes them by width.
  task automatic host_cmd(input int nbits, input logic [15:0] exp, input string tag);
    int n, lo, hi, bad_t;
    logic [15:0] got;
    got = '0; bad_t = 0;
    wait_pull(1'b1, n);
    wait_pull(1'b0, n);
    chk(n == 200, {tag, " R2 break width"}, n, 200);
    wait_pull(1'b1, n);
    chk(n == 50, {tag, " R2 recovery gap"}, n, 50);
    for (int i = 0; i < nbits; i++) begin
      wait_pull(1'b0, n);
      lo = n;
      if (lo == 30)       got[i] = 1'b1;
      else if (lo == 115) got[i] = 1'b0;
      else                bad_t++;
      if (i < nbits - 1) begin
        wait_pull(1'b1, n);
        hi = n;
        if (lo + hi != 200) bad_t++;
      end
    end
    chk(bad_t == 0, {tag, " R3 bit pulse/period timing errors"}, bad_t, 0);
    chk(got == exp, {tag, " R4 transmitted word"}, int'(got), int'(exp));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; ifrst_req = 1'b0; dev_pull = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(line_pull == 1'b0, "R1 line released", line_pull, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(err_timeout == 1'b0 && err_frame == 1'b0, "R1 errors", {err_timeout, err_frame}, 0);
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
  endtask

  task automatic t_write(input logic [6:0] a, input logic [7:0] d, input logic [7:0] prev_rd);
    int n, bad, expn;
    start_req(1'b1, a, d);
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    fork
      host_cmd(16, {d, 1'b1, a}, "write");
      begin
        repeat (400) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = ~a; req_wdata = ~d;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    expn = d[7] ? 170 : 85;
    wait_done(n);
    chk(n == expn, "R4 done after final bit period", n, expn);
    chk(!err_timeout && !err_frame, "R4 write without error", {err_timeout, err_frame}, 0);
    chk(rdata == prev_rd, "R12 write leaves rdata", rdata, prev_rd);
    bad = 0;
    repeat (400) begin
      @(negedge clk);
      if (line_pull || busy) bad++;
    end
    chk(bad == 0, "R10 request during busy ignored", bad, 0);
  endtask

  task automatic t_read(input logic [6:0] a, input logic [7:0] d, input bit rnd);
    int n, l, h;
    start_req(1'b0, a, 8'h00);
    host_cmd(8, {8'h00, 1'b0, a}, "read");
    repeat (100) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (d[i]) l = rnd ? int'($urandom_range(22, 48))  : ((i % 2) ? 50 : 20);
      else      l = rnd ? int'($urandom_range(85, 140)) : ((i % 2) ? 145 : 80);
      h = rnd ? int'($urandom_range(190, 240)) - l : 200 - l;
      dev_pull = 1'b1;
      repeat (l) @(negedge clk);
      dev_pull = 1'b0;
      if (i < 7) repeat (h) @(negedge clk);
    end
    wait_done(n);
    chk(n >= 210 && n <= 216, "R8 turnaround before done", n, 213);
    chk(rdata == d, "R5 decoded byte", rdata, d);
    chk(!err_timeout && !err_frame, "R5 read without error", {err_timeout, err_frame}, 0);
  endtask

  task automatic t_bad(input logic [6:0] a, input int l);
    int n;
    start_req(1'b0, a, 8'h00);
    host_cmd(8, {8'h00, 1'b0, a}, "badread");
    repeat (100) @(negedge clk);
    dev_pull = 1'b1;
    repeat (l) @(negedge clk);
    dev_pull = 1'b0;
    wait_done(n);
    chk(err_frame == 1'b1, $sformatf("R6 frame error for width %0d", l), err_frame, 1);
    chk(err_timeout == 1'b0, "R6 no timeout flag", err_timeout, 0);
  endtask

  task automatic t_timeout(input logic [6:0] a);
    int n;
    start_req(1'b0, a, 8'h00);
    host_cmd(8, {8'h00, 1'b0, a}, "silent");
    wait_done(n);
    chk(err_timeout == 1'b1, "R7 timeout flag", err_timeout, 1);
    chk(err_frame == 1'b0, "R7 no frame flag", err_frame, 0);
    chk(n >= 399 && n <= 401, "R7 window plus R8 turnaround", n, 400);
  endtask

  task automatic t_ifrst(input bit both);
    int n;
    @(negedge clk);
    ifrst_req = 1'b1;
    if (both) begin req_valid = 1'b1; req_write = 1'b1; end
    @(negedge clk);
    ifrst_req = 1'b0; req_valid = 1'b0;
    wait_pull(1'b1, n);
    wait_pull(1'b0, n);
    chk(n == 3000, both ? "R11 reset wins over request" : "R9 reset low width", n, 3000);
    chk(done == 1'b1, "R9 done at release", done, 1);
    chk(!err_timeout && !err_frame, "R9 no error", {err_timeout, err_frame}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: run did not finish actual=%0d expected=%0d", 150000, 0);
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_read(7'h0B, 8'hA5, 1'b0);
    t_write(7'h35, 8'hC3, 8'hA5);
    t_read(7'h12, 8'h3C, 1'b1);
    t_read(7'h61, 8'hE8, 1'b1);
    t_bad(7'h22, 19);
    t_bad(7'h22, 65);
    t_bad(7'h22, 146);
    t_timeout(7'h44);
    t_ifrst(1'b0);
    t_ifrst(1'b1);
    repeat (10) @(negedge clk);
    report();
    $finish;
  end
endmodule